// File: doc/BRIEF.md
# Accumulator Logic-Instruction Execution Unit

This unit carries out the bitwise-logic and rotate instructions of a classic 8-bit accumulator machine, one instruction at a time. A byte source presents an opcode byte, and then up to two operand bytes, on a valid/ready handshake. The unit decodes the opcode and reads its operand from one of four places: a working register, a byte addressed indirectly through a pointer register, a directly addressed byte, or an immediate value. It then updates either the accumulator (with its carry flag) or the addressed data byte.

The eight working registers occupy locations 0 to 7 of a 128-byte internal data store that lives inside the unit. A direct write to one of those locations therefore changes the matching register. Each instruction ends with a one-cycle done pulse. An opcode outside the group gives a one-cycle illegal flag instead, and no state changes.

Top module: `acc_logic_unit`

## Requirements
- R1: After reset the accumulator is 0x00, carry is 0, every data-store byte (working registers included) is 0x00, done and illegal are low, and in_ready is high.
- R2: The AND forms set A to A AND operand. Opcodes 0x58..0x5F take working register n, where n is opcode bits 2:0 and register n is data-store location n. 0x55 takes the byte at the address given by the next byte. 0x56/0x57 take the byte whose address is held in register 0 or register 1 (opcode bit 0). 0x54 takes the next byte itself.
- R3: The OR forms at 0x48..0x4F, 0x45, 0x46/0x47 and 0x44, and the XOR forms at 0x68..0x6F, 0x65, 0x66/0x67 and 0x64, address their operand exactly as in R2 and set A to A OR operand or A XOR operand.
- R4: Opcodes 0x52, 0x42 and 0x62 are two bytes long. They replace the data byte at the address in byte 2 with that byte AND, OR or XOR A, and leave A and carry unchanged.
- R5: Opcodes 0x53, 0x43 and 0x63 are three bytes long: opcode, then address, then immediate. They replace the addressed byte with that byte AND, OR or XOR the immediate. In the cycle after the last byte is taken, in_ready and done are both low. Done is high in the cycle after that.
- R6: Only bits 6:0 of a direct address, and of a pointer register's value used by an indirect form, select the data byte. Bit 7 is ignored.
- R7: 0xE4 sets A to 0x00, 0xF4 sets A to its bitwise complement, and 0xC4 swaps the two halves of A. None of them changes carry.
- R8: 0x23 rotates A left by one, with bit 7 moving to bit 0. 0x03 rotates A right by one, with bit 0 moving to bit 7. Carry is unchanged.
- R9: 0x33 rotates A left through carry: the old carry goes to bit 0 and the old bit 7 becomes the carry. 0x13 rotates A right through carry: the old carry goes to bit 7 and the old bit 0 becomes the carry.
- R10: For every one- and two-byte form, done is high for the single cycle right after the clock edge that takes the final byte, and the new A, carry and data byte are visible in that cycle.
- R11: Every other opcode is one byte long. It makes illegal high, with done low, for the single cycle after the opcode is taken, and leaves A, carry and the data store unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction byte present on in_byte |
| in_byte | input | 8 | Opcode or operand byte |
| in_ready | output | 1 | Unit takes in_byte at this edge when in_valid is high |
| acc | output | 8 | Accumulator |
| carry | output | 1 | Carry flag |
| done | output | 1 | One-cycle pulse when an instruction completes |
| illegal | output | 1 | One-cycle pulse for an opcode outside the group |

## Verification
The data store can only be seen through the accumulator, and its only writers are the logic-to-memory forms. So the state an indirect or register form reads has to be built up first, with OR and AND immediate-to-memory instructions that also clobber the pointer registers. The bench sweeps all 256 opcodes in several passes. Before each instruction it loads A with a fresh value, and it picks operand addresses that often have bit 7 set and often land on locations 0 and 1. The pointers therefore keep moving under a running model, and each pass ends by reading back all 128 locations through the accumulator.

// File: rtl/acc_logic_pkg.sv
package acc_logic_pkg;

   typedef enum logic [3:0] {
      FN_AND, FN_OR, FN_XOR, FN_CLR, FN_CPL,
      FN_SWAP, FN_RL, FN_RR, FN_RLC, FN_RRC
   } func_e;

   typedef enum logic [2:0] {
      SRC_NONE, SRC_REG, SRC_IND, SRC_DIR, SRC_IMM
   } src_e;

   typedef struct packed {
      logic       legal;
      func_e      func;
      src_e       src;
      logic       to_mem;
      logic       imm_to_mem;
      logic [1:0] n_args;
   } dec_t;

   typedef enum logic [1:0] {
      ST_OP, ST_ARG1, ST_ARG2, ST_EXEC
   } state_e;

endpackage

// File: rtl/acc_logic_dec.sv
module acc_logic_dec
   import acc_logic_pkg::*;
(
   input  logic [7:0] op,
   output dec_t       d
);

   logic [3:0] hi;
   logic [3:0] lo;

   always_comb begin
      hi = op[7:4];
      lo = op[3:0];
      d  = '0;
      d.func = FN_AND;
      d.src  = SRC_NONE;
      if ((hi == 4'h4 || hi == 4'h5 || hi == 4'h6) && lo[3:1] != 3'b000) begin
         d.legal = 1'b1;
         d.func  = (hi == 4'h5) ? FN_AND : ((hi == 4'h4) ? FN_OR : FN_XOR);
         if (lo[3]) begin
            d.src = SRC_REG;
         end else if (lo[2:1] == 2'b11) begin
            d.src = SRC_IND;
         end else if (lo == 4'h5) begin
            d.src    = SRC_DIR;
            d.n_args = 2'd1;
         end else if (lo == 4'h4) begin
            d.src    = SRC_IMM;
            d.n_args = 2'd1;
         end else if (lo == 4'h2) begin
            d.src    = SRC_DIR;
            d.to_mem = 1'b1;
            d.n_args = 2'd1;
         end else begin
            d.src        = SRC_DIR;
            d.to_mem     = 1'b1;
            d.imm_to_mem = 1'b1;
            d.n_args     = 2'd2;
         end
      end else begin
         d.legal = 1'b1;
         case (op)
            8'hE4:   d.func = FN_CLR;
            8'hF4:   d.func = FN_CPL;
            8'hC4:   d.func = FN_SWAP;
            8'h23:   d.func = FN_RL;
            8'h03:   d.func = FN_RR;
            8'h33:   d.func = FN_RLC;
            8'h13:   d.func = FN_RRC;
            default: d.legal = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/acc_logic_alu.sv
module acc_logic_alu
   import acc_logic_pkg::*;
#(
   parameter int W = 8
) (
   input  func_e          func,
   input  logic [W-1:0]   x,
   input  logic [W-1:0]   y,
   input  logic           cy_in,
   output logic [W-1:0]   res,
   output logic           cy_out
);

   localparam int H = W / 2;

   generate
      if (W % 2 != 0 || W < 2) begin : g_bad_width
         $error("acc_logic_alu: W must be even and at least 2");
      end
   endgenerate

   always_comb begin
      cy_out = cy_in;
      case (func)
         FN_AND:  res = x & y;
         FN_OR:   res = x | y;
         FN_XOR:  res = x ^ y;
         FN_CLR:  res = '0;
         FN_CPL:  res = ~x;
         FN_SWAP: res = {x[H-1:0], x[W-1:H]};
         FN_RL:   res = {x[W-2:0], x[W-1]};
         FN_RR:   res = {x[0], x[W-1:1]};
         FN_RLC: begin
            res    = {x[W-2:0], cy_in};
            cy_out = x[W-1];
         end
         FN_RRC: begin
            res    = {cy_in, x[W-1:1]};
            cy_out = x[0];
         end
         default: res = x;
      endcase
   end

endmodule

// File: rtl/acc_logic_store.sv
module acc_logic_store #(
   parameter int W     = 8,
   parameter int DEPTH = 128,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] rd0_addr,
   output logic [W-1:0]  rd0_data,
   input  logic [AW-1:0] rd1_addr,
   output logic [W-1:0]  rd1_data,
   input  logic          we,
   input  logic [AW-1:0] wr_addr,
   input  logic [W-1:0]  wr_data
);

   generate
      if (DEPTH != (1 << AW)) begin : g_bad_depth
         $error("acc_logic_store: DEPTH must be a power of two");
      end
   endgenerate

   logic [W-1:0] cells [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
      end else if (we) begin
         cells[wr_addr] <= wr_data;
      end
   end

   assign rd0_data = cells[rd0_addr];
   assign rd1_data = cells[rd1_addr];

endmodule

// File: rtl/acc_logic_unit.sv
module acc_logic_unit
   import acc_logic_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int MEM_DEPTH = 128,
   parameter int REG_COUNT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_byte,
   output logic              in_ready,
   output logic [DATA_W-1:0] acc,
   output logic              carry,
   output logic              done,
   output logic              illegal
);

   localparam int AW  = $clog2(MEM_DEPTH);
   localparam int RAW = $clog2(REG_COUNT);

   generate
      if (DATA_W != 8) begin : g_bad_w
         $error("acc_logic_unit: the opcode map needs DATA_W == 8");
      end
      if (REG_COUNT != 8) begin : g_bad_regs
         $error("acc_logic_unit: opcode bits 2:0 select one of 8 registers");
      end
      if (AW >= DATA_W || MEM_DEPTH < REG_COUNT) begin : g_bad_depth
         $error("acc_logic_unit: MEM_DEPTH out of range");
      end
   endgenerate

   state_e            st;
   logic [DATA_W-1:0] op_q, addr_q, data_q;
   logic [DATA_W-1:0] cur_op, arg1, ptr, x, y, res, rd1_data;
   logic [AW-1:0]     rd0_addr, rd1_addr;
   logic              take, exec, cy_out, at_opcode;
   dec_t              d;

   assign in_ready  = (st != ST_EXEC);
   assign take      = in_valid && in_ready;
   assign at_opcode = (st == ST_OP);
   assign cur_op    = at_opcode ? in_byte : op_q;
   assign arg1      = (st == ST_ARG1) ? in_byte : addr_q;

   acc_logic_dec u_dec (.op(cur_op), .d(d));

   assign rd0_addr = {{(AW-1){1'b0}}, cur_op[0]};

   always_comb begin
      case (d.src)
         SRC_REG: rd1_addr = {{(AW-RAW){1'b0}}, cur_op[RAW-1:0]};
         SRC_IND: rd1_addr = ptr[AW-1:0];
         default: rd1_addr = arg1[AW-1:0];
      endcase
   end

   assign x = d.to_mem ? rd1_data : acc;
   assign y = d.to_mem ? (d.imm_to_mem ? data_q : acc)
                       : ((d.src == SRC_IMM) ? arg1 : rd1_data);

   assign exec = (at_opcode && take && d.legal && d.n_args == 2'd0)
              || (st == ST_ARG1 && take && !d.imm_to_mem)
              || (st == ST_EXEC);

   acc_logic_store #(.W(DATA_W), .DEPTH(MEM_DEPTH), .AW(AW)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd0_addr (rd0_addr),
      .rd0_data (ptr),
      .rd1_addr (rd1_addr),
      .rd1_data (rd1_data),
      .we       (exec && d.to_mem),
      .wr_addr  (arg1[AW-1:0]),
      .wr_data  (res)
   );

   acc_logic_alu #(.W(DATA_W)) u_alu (
      .func   (d.func),
      .x      (x),
      .y      (y),
      .cy_in  (carry),
      .res    (res),
      .cy_out (cy_out)
   );

   wire unused_bits = ^{ptr[DATA_W-1:AW], arg1[DATA_W-1:AW]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_OP;
         op_q    <= '0;
         addr_q  <= '0;
         data_q  <= '0;
         acc     <= '0;
         carry   <= 1'b0;
         done    <= 1'b0;
         illegal <= 1'b0;
      end else begin
         done    <= exec;
         illegal <= at_opcode && take && !d.legal;
         if (exec && !d.to_mem) begin
            acc   <= res;
            carry <= cy_out;
         end
         case (st)
            ST_OP: begin
               if (take && d.legal && d.n_args != 2'd0) begin
                  op_q <= in_byte;
                  st   <= ST_ARG1;
               end
            end
            ST_ARG1: begin
               if (take) begin
                  addr_q <= in_byte;
                  st     <= d.imm_to_mem ? ST_ARG2 : ST_OP;
               end
            end
            ST_ARG2: begin
               if (take) begin
                  data_q <= in_byte;
                  st     <= ST_EXEC;
               end
            end
            default: st <= ST_OP;
         endcase
      end
   end

endmodule

// File: rtl/acc_logic_chk.sv
module acc_logic_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic       in_ready,
   input logic [7:0] in_byte,
   input logic [7:0] acc,
   input logic       carry,
   input logic       done,
   input logic       illegal,
   input logic       at_opcode
);

   wire op_take = at_opcode && in_valid && in_ready;

   p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (acc == 8'h00 && !carry && !done && !illegal && in_ready));

   p_exec_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |-> (!done && !illegal));

   p_exec_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |=> in_ready);

   p_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_take && in_byte == 8'hC4) |=>
         (acc == {$past(acc[3:0]), $past(acc[7:4])} && carry == $past(carry)));

   p_rl_keeps_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_take && in_byte == 8'h23) |=>
         (acc == {$past(acc[6:0]), $past(acc[7])} && carry == $past(carry)));

   p_rlc_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_take && in_byte == 8'h33) |=>
         (acc == {$past(acc[6:0]), $past(carry)} && carry == $past(acc[7])));

   p_rrc_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_take && in_byte == 8'h13) |=>
         (acc == {$past(carry), $past(acc[7:1])} && carry == $past(acc[0])));

   p_done_one_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (op_take && in_byte == 8'hE4) |=> (done && acc == 8'h00));

   p_illegal_keeps_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> ($stable(acc) && $stable(carry) && !done));

endmodule

bind acc_logic_unit acc_logic_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_byte   (in_byte),
   .acc       (acc),
   .carry     (carry),
   .done      (done),
   .illegal   (illegal),
   .at_opcode (at_opcode)
);

// File: tb/tb_acc_logic_unit.sv
module tb_acc_logic_unit;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic       in_ready;
   logic [7:0] acc;
   logic       carry;
   logic       done;
   logic       illegal;

   int n_cmp = 0;
   int n_bad = 0;

   logic [7:0] m_acc;
   logic       m_cy;
   logic [7:0] m_mem [128];

   always #5 clk = ~clk;

   acc_logic_unit dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .in_ready(in_ready), .acc(acc), .carry(carry), .done(done), .illegal(illegal)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] lf(input logic [3:0] hi, input logic [7:0] a, input logic [7:0] b);
      if (hi == 4'h5) return a & b;
      else if (hi == 4'h4) return a | b;
      else return a ^ b;
   endfunction

   task automatic send(input logic [7:0] b);
      in_byte  = b;
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic run(input logic [7:0] op, input logic [7:0] b1,
                      input logic [7:0] b2, input string tag);
      logic [3:0] hi, lo;
      logic [7:0] y;
      int n, kind;
      string t;
      hi = op[7:4];
      lo = op[3:0];
      n = 0; kind = 0; t = "R11"; y = 8'h00;
      if ((hi == 4'h4 || hi == 4'h5 || hi == 4'h6) && lo != 4'h0 && lo != 4'h1) begin
         t = (hi == 4'h5) ? "R2" : "R3";
         if (lo >= 4'h8) y = m_mem[lo[2:0]];
         else if (lo == 4'h6 || lo == 4'h7) y = m_mem[m_mem[lo[0]][6:0]];
         else if (lo == 4'h5) begin y = m_mem[b1[6:0]]; n = 1; end
         else if (lo == 4'h4) begin y = b1; n = 1; end
         if (lo >= 4'h4) m_acc = lf(hi, m_acc, y);
         else if (lo == 4'h2) begin
            n = 1; t = "R4";
            m_mem[b1[6:0]] = lf(hi, m_mem[b1[6:0]], m_acc);
         end else begin
            n = 2; kind = 1; t = "R5";
            m_mem[b1[6:0]] = lf(hi, m_mem[b1[6:0]], b2);
         end
      end else begin
         case (op)
            8'hE4: begin m_acc = 8'h00; t = "R7"; end
            8'hF4: begin m_acc = ~m_acc; t = "R7"; end
            8'hC4: begin m_acc = {m_acc[3:0], m_acc[7:4]}; t = "R7"; end
            8'h23: begin m_acc = {m_acc[6:0], m_acc[7]}; t = "R8"; end
            8'h03: begin m_acc = {m_acc[0], m_acc[7:1]}; t = "R8"; end
            8'h33: begin {m_cy, m_acc} = {m_acc, m_cy}; t = "R9"; end
            8'h13: begin {m_acc, m_cy} = {m_cy, m_acc}; t = "R9"; end
            default: kind = 2;
         endcase
      end
      if (tag != "") t = tag;
      send(op);
      if (n >= 1) send(b1);
      if (n == 2) send(b2);
      if (kind == 2) begin
         chk("R11 illegal", {7'b0, illegal}, 8'h01);
         chk("R11 done", {7'b0, done}, 8'h00);
      end else if (kind == 1) begin
         chk("R5 ready gap", {7'b0, in_ready}, 8'h00);
         chk("R5 done gap", {7'b0, done}, 8'h00);
         @(negedge clk);
         chk("R5 done", {7'b0, done}, 8'h01);
      end else begin
         chk("R10 done", {7'b0, done}, 8'h01);
         chk("R10 illegal", {7'b0, illegal}, 8'h00);
      end
      chk({t, " acc"}, acc, m_acc);
      chk({t, " carry"}, {7'b0, carry}, {7'b0, m_cy});
   endtask

   task automatic readback(input string tag);
      for (int a = 0; a < 128; a++) begin
         run(8'hE4, 8'h00, 8'h00, tag);
         run(8'h45, 8'(a), 8'h00, tag);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
   end

   initial begin
      m_acc = 8'h00;
      m_cy  = 1'b0;
      for (int i = 0; i < 128; i++) m_mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state at the ports
      chk("R1 acc", acc, 8'h00);
      chk("R1 carry", {7'b0, carry}, 8'h00);
      chk("R1 done", {7'b0, done}, 8'h00);
      chk("R1 illegal", {7'b0, illegal}, 8'h00);
      chk("R1 ready", {7'b0, in_ready}, 8'h01);
      readback("R1");

      // R6: address bit 7 ignored for direct and indirect forms
      run(8'h43, 8'h85, 8'hA6, "R6");
      run(8'hE4, 8'h00, 8'h00, "R6");
      run(8'h45, 8'h05, 8'h00, "R6");
      chk("R6 direct alias", acc, 8'hA6);
      run(8'h43, 8'h80, 8'h93, "R6");
      run(8'h43, 8'h13, 8'h5A, "R6");
      run(8'hE4, 8'h00, 8'h00, "R6");
      run(8'h46, 8'h00, 8'h00, "R6");
      chk("R6 indirect alias", acc, 8'h5A);

      // R9: through-carry rotates with known carry
      run(8'hE4, 8'h00, 8'h00, "R9");
      run(8'h44, 8'h81, 8'h00, "R9");
      run(8'h33, 8'h00, 8'h00, "R9");
      chk("R9 rlc value", acc, 8'h02);
      chk("R9 rlc carry", {7'b0, carry}, 8'h01);
      run(8'h13, 8'h00, 8'h00, "R9");
      chk("R9 rrc value", acc, 8'h81);
      chk("R9 rrc carry", {7'b0, carry}, 8'h00);

      // full opcode sweep, several passes with shifting operands
      for (int p = 0; p < 4; p++) begin
         for (int op = 0; op < 256; op++) begin
            run(8'hE4, 8'h00, 8'h00, "");
            run(8'h44, 8'(op * 29 + p * 71 + 5), 8'h00, "");
            run(8'(op), 8'((op * 13 + p * 97 + 3) & ((p == 1) ? 8'h81 : 8'hFF)),
                8'(op ^ (p * 55)), "");
         end
         readback("R4");
      end
      summary();
   end

endmodule